// File: doc/BRIEF.md
# Audio Master Clock Divider

This block produces the three clocks of a serial audio link (master clock, bit clock and frame clock) from an audio reference clock. It is used only when the interface is the bus master. All counting runs in the reference clock domain, and every output is a registered level. A stop request never cuts a frame short, so the frame clock always completes its period.

A 6-bit divide field `div` sets the master-clock period to `div+1` reference cycles. The frame clock carries two channel slots of 32 bit-clock periods each. With the master-clock output mode selected, each bit period lasts `(ratio+1)/2` master-clock periods. This gives `fs = ref / ((div+1) * 32 * (ratio+1))`. With that mode off, the master-clock pin stays low and the bit clock is produced straight from the divided reference, with a period of `div+1` cycles.

Control is a three-state machine:
- **IDLE** is the reset state, with all clocks held low.
- **RUN** means the clocks are being generated.
- **DRAIN** means a stop has been requested and the current frame is being finished.

The transitions are:
- **START** (IDLE→RUN) is accepted in master mode with a valid setting, and latches the divider inputs.
- **STOP_REQ** (RUN→DRAIN) is taken on a stop request in mid-frame.
- **STOP_NOW** (RUN→IDLE) is taken on a stop request in the last cycle of a frame.
- **RESUME** (DRAIN→RUN) is taken on a start request during DRAIN.
- **FRAME_DONE** (DRAIN→IDLE) is taken at the end of the frame.

Top module: `aud_clkgen`

## Requirements
- R1: During and after reset the generator is idle and `mclk_o`, `bclk_o`, `lrclk_o` and `gen_active_o` are all low.
- R2: While running with `mck_out_i`=1 latched, `mclk_o` has a period of N=div+1 cycles. It is low for the first floor(N/2) cycles of each period and then high. With `mck_out_i`=0 latched, it stays low.
- R3: Count j from the cycle after START (j=0). `bclk_o` is high exactly when (j mod P) ≥ floor(P/2). P is (ratio+1)/2·(div+1) with `mck_out_i`=1 and div+1 with `mck_out_i`=0.
- R4: `lrclk_o` is low for bit periods 0–31 of each 64-bit frame and high for periods 32–63. It therefore changes only at the start of a bit period, while `bclk_o` is low.
- R5: `cfg_bad_o` is high when div=0, or when `mck_out_i`=1 and ratio is even. A start request while it is high leaves the generator idle.
- R6: A start request with `master_i`=0 (slave) is ignored.
- R7: Suppose a stop request is sampled at the edge that ends cycle J. The clocks keep running through the last cycle of the frame that contains J, and all outputs are low from the next cycle on.
- R8: A stop request while idle has no effect. When start and stop are requested in the same cycle, stop wins.
- R9: A start request during DRAIN cancels the pending stop without restarting the phase. A start request during RUN has no effect on the phase.
- R10: The divider and mode inputs are sampled only at START. Changing them while the generator runs does not alter any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Audio reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_i | input | 1 | 1 = bus master, 0 = slave (generator unused) |
| mck_out_i | input | 1 | 1 = generate master clock on `mclk_o`, 0 = bit clock from divided reference |
| mck_div_i | input | 6 | Master-clock divide field (period div+1) |
| fs_ratio_i | input | 6 | Frame ratio field (bit period (ratio+1)/2 master clocks) |
| ck_start_i | input | 1 | Clock enable command |
| ck_stop_i | input | 1 | Clock disable command |
| mclk_o | output | 1 | Generated master clock |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame (word-select) clock |
| gen_active_o | output | 1 | Generator running (RUN or DRAIN) |
| cfg_bad_o | output | 1 | Current divider setting is not usable |

## Verification
The assertions assume that the command and setting inputs are synchronous to the reference clock and carry known values once reset is released. Under that assumption they can relate a stop, a slave setting or a bad setting to the activity flag one cycle later. The bench changes every input 1 ns after a rising edge and samples 1 ns after the edge. Each command therefore lands on exactly one predictable edge, and the settings it uses are small enough that a whole frame fits in a few hundred cycles.

// File: rtl/aud_clkgen_pkg.sv
package aud_clkgen_pkg;

    // Generator control states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } gen_state_e;

endpackage

// File: rtl/aud_clkgen_cfg.sv
// Decodes the divider inputs into periods and a usability flag.
module aud_clkgen_cfg #(
    parameter int DIV_W = 6,
    parameter int RAT_W = 6,
    parameter int PER_W = DIV_W + RAT_W
) (
    input  logic             mck_out_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [RAT_W-1:0] ratio_i,
    output logic             bad_o,
    output logic [DIV_W:0]   mck_per_o,
    output logic [PER_W-1:0] bit_per_o
);
    localparam logic [DIV_W:0]   DIV_ONE = {{DIV_W{1'b0}}, 1'b1};
    localparam logic [RAT_W-1:0] RAT_ONE = {{(RAT_W-1){1'b0}}, 1'b1};

    logic [RAT_W-1:0] mck_per_bit;

    always_comb begin
        mck_per_o   = {1'b0, div_i} + DIV_ONE;
        // (ratio+1)/2 for an odd ratio
        mck_per_bit = (ratio_i >> 1) + RAT_ONE;
        bad_o       = (div_i == '0) || (mck_out_i && !ratio_i[0]);
        if (mck_out_i) begin
            bit_per_o = PER_W'(mck_per_bit) * PER_W'(mck_per_o);
        end else begin
            bit_per_o = PER_W'(mck_per_o);
        end
    end

endmodule

// File: rtl/aud_clkgen_fsm.sv
// Start/stop control with frame-aligned stop.
module aud_clkgen_fsm
    import aud_clkgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic master_i,
    input  logic cfg_bad_i,
    input  logic frame_end_i,
    output logic load_o,
    output logic active_o,
    output logic act_next_o
);
    gen_state_e state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                // START
                if (start_i && !stop_i && master_i && !cfg_bad_i) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                // STOP_NOW or STOP_REQ
                if (stop_i) begin
                    state_d = frame_end_i ? ST_IDLE : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                // RESUME has priority over FRAME_DONE
                if (start_i && !stop_i) begin
                    state_d = ST_RUN;
                end else if (frame_end_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        load_o     = (state_q == ST_IDLE) && (state_d == ST_RUN);
        active_o   = (state_q != ST_IDLE);
        act_next_o = (state_d != ST_IDLE);
    end

endmodule

// File: rtl/aud_clkgen_div.sv
// Counter chain: master-clock phase, bit phase and bit index in frame.
module aud_clkgen_div #(
    parameter int DIV_W     = 6,
    parameter int PER_W     = 12,
    parameter int SLOT_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             cont_i,
    input  logic             act_next_i,
    input  logic             mck_out_i,
    input  logic [DIV_W:0]   mck_per_i,
    input  logic [PER_W-1:0] bit_per_i,
    output logic             frame_end_o,
    output logic             mclk_o,
    output logic             bclk_o,
    output logic             lrclk_o
);
    localparam int FRAME_BITS = 2 * SLOT_BITS;
    localparam int BIT_CW     = $clog2(FRAME_BITS);
    localparam logic [BIT_CW-1:0] LAST_BIT  = BIT_CW'(FRAME_BITS - 1);
    localparam logic [BIT_CW-1:0] SLOT2_BIT = BIT_CW'(SLOT_BITS);
    localparam logic [BIT_CW-1:0] BIT_ONE   = {{(BIT_CW-1){1'b0}}, 1'b1};
    localparam logic [DIV_W:0]    MCK_ONE   = {{DIV_W{1'b0}}, 1'b1};
    localparam logic [PER_W-1:0]  PER_ONE   = {{(PER_W-1){1'b0}}, 1'b1};

    // Settings latched at START
    logic             mode_q;
    logic [DIV_W:0]   mper_q;
    logic [PER_W-1:0] bper_q;

    logic [DIV_W:0]    mck_q, mck_d;
    logic [PER_W-1:0]  ph_q, ph_d;
    logic [BIT_CW-1:0] bit_q, bit_d;
    logic              ph_wrap;
    logic              gen;

    always_comb begin
        ph_wrap     = (ph_q == bper_q - PER_ONE);
        frame_end_o = cont_i && ph_wrap && (bit_q == LAST_BIT);
        gen         = act_next_i && cont_i;
        mck_d       = '0;
        ph_d        = '0;
        bit_d       = '0;
        if (gen) begin
            mck_d = (mck_q == mper_q - MCK_ONE) ? '0 : mck_q + MCK_ONE;
            if (ph_wrap) begin
                ph_d  = '0;
                bit_d = (bit_q == LAST_BIT) ? '0 : bit_q + BIT_ONE;
            end else begin
                ph_d  = ph_q + PER_ONE;
                bit_d = bit_q;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            mper_q <= '0;
            bper_q <= '0;
        end else if (load_i) begin
            mode_q <= mck_out_i;
            mper_q <= mck_per_i;
            bper_q <= bit_per_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mck_q   <= '0;
            ph_q    <= '0;
            bit_q   <= '0;
            mclk_o  <= 1'b0;
            bclk_o  <= 1'b0;
            lrclk_o <= 1'b0;
        end else begin
            mck_q   <= mck_d;
            ph_q    <= ph_d;
            bit_q   <= bit_d;
            mclk_o  <= gen && mode_q && (mck_d >= (mper_q >> 1));
            bclk_o  <= gen && (ph_d >= (bper_q >> 1));
            lrclk_o <= gen && (bit_d >= SLOT2_BIT);
        end
    end

endmodule

// File: rtl/aud_clkgen.sv
// Audio master/bit/frame clock generator, top level.
module aud_clkgen #(
    parameter int DIV_W     = 6,
    parameter int RAT_W     = 6,
    parameter int SLOT_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_i,
    input  logic             mck_out_i,
    input  logic [DIV_W-1:0] mck_div_i,
    input  logic [RAT_W-1:0] fs_ratio_i,
    input  logic             ck_start_i,
    input  logic             ck_stop_i,
    output logic             mclk_o,
    output logic             bclk_o,
    output logic             lrclk_o,
    output logic             gen_active_o,
    output logic             cfg_bad_o
);
    localparam int PER_W = DIV_W + RAT_W;

    logic [DIV_W:0]   mck_per;
    logic [PER_W-1:0] bit_per;
    logic             load, act_next, frame_end;

    aud_clkgen_cfg #(.DIV_W(DIV_W), .RAT_W(RAT_W), .PER_W(PER_W)) u_cfg (
        .mck_out_i (mck_out_i),
        .div_i     (mck_div_i),
        .ratio_i   (fs_ratio_i),
        .bad_o     (cfg_bad_o),
        .mck_per_o (mck_per),
        .bit_per_o (bit_per)
    );

    aud_clkgen_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (ck_start_i),
        .stop_i      (ck_stop_i),
        .master_i    (master_i),
        .cfg_bad_i   (cfg_bad_o),
        .frame_end_i (frame_end),
        .load_o      (load),
        .active_o    (gen_active_o),
        .act_next_o  (act_next)
    );

    aud_clkgen_div #(.DIV_W(DIV_W), .PER_W(PER_W), .SLOT_BITS(SLOT_BITS)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .cont_i      (gen_active_o),
        .act_next_i  (act_next),
        .mck_out_i   (mck_out_i),
        .mck_per_i   (mck_per),
        .bit_per_i   (bit_per),
        .frame_end_o (frame_end),
        .mclk_o      (mclk_o),
        .bclk_o      (bclk_o),
        .lrclk_o     (lrclk_o)
    );

endmodule

// File: rtl/aud_clkgen_chk.sv
// Property checker, bound to the top module.
module aud_clkgen_chk (
    input logic clk,
    input logic rst_n,
    input logic master_i,
    input logic ck_stop_i,
    input logic mclk_o,
    input logic bclk_o,
    input logic lrclk_o,
    input logic gen_active_o,
    input logic cfg_bad_o
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_active_o |-> !(mclk_o || bclk_o || lrclk_o));

    // R4
    frame_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_active_o && $past(gen_active_o) && (lrclk_o != $past(lrclk_o))) |-> !bclk_o);

    // R5
    bad_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bad_o && !gen_active_o) |=> !gen_active_o);

    // R6
    slave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_i && !gen_active_o) |=> !gen_active_o);

    // R7
    full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gen_active_o) |-> ($past(lrclk_o) && $past(bclk_o)));

    // R8
    idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_active_o && ck_stop_i) |=> !gen_active_o);

endmodule

bind aud_clkgen aud_clkgen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .master_i     (master_i),
    .ck_stop_i    (ck_stop_i),
    .mclk_o       (mclk_o),
    .bclk_o       (bclk_o),
    .lrclk_o      (lrclk_o),
    .gen_active_o (gen_active_o),
    .cfg_bad_o    (cfg_bad_o)
);

// File: tb/aud_clkgen_tb.sv
module aud_clkgen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_i = 1'b1;
    logic       mck_out_i = 1'b1;
    logic [5:0] mck_div_i = 6'd1;
    logic [5:0] fs_ratio_i = 6'd1;
    logic       ck_start_i = 1'b0;
    logic       ck_stop_i = 1'b0;
    logic       mclk_o, bclk_o, lrclk_o, gen_active_o, cfg_bad_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    aud_clkgen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .master_i     (master_i),
        .mck_out_i    (mck_out_i),
        .mck_div_i    (mck_div_i),
        .fs_ratio_i   (fs_ratio_i),
        .ck_start_i   (ck_start_i),
        .ck_stop_i    (ck_stop_i),
        .mclk_o       (mclk_o),
        .bclk_o       (bclk_o),
        .lrclk_o      (lrclk_o),
        .gen_active_o (gen_active_o),
        .cfg_bad_o    (cfg_bad_o)
    );

    always #5ns clk = ~clk;

    typedef struct packed {
        logic        mode;
        logic [5:0]  div;
        logic [5:0]  fsr;
        logic        bad;
        logic [11:0] stop_at;
        logic        poke;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 6'd1, 6'd1, 1'b0, 12'd50,  1'b0},
        '{1'b1, 6'd2, 6'd3, 1'b0, 12'd383, 1'b1},
        '{1'b0, 6'd2, 6'd0, 1'b0, 12'd10,  1'b0},
        '{1'b1, 6'd3, 6'd5, 1'b0, 12'd700, 1'b0},
        '{1'b0, 6'd0, 6'd3, 1'b1, 12'd0,   1'b0},
        '{1'b1, 6'd2, 6'd2, 1'b1, 12'd0,   1'b0},
        '{1'b1, 6'd0, 6'd1, 1'b1, 12'd0,   1'b0},
        '{1'b0, 6'd4, 6'd2, 1'b0, 12'd100, 1'b0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1ns;
    endtask

    task automatic run_vec(input vec_t v);
        int n, p, f, last;
        int miss [4];
        int mj [4];
        int ma [4];
        int me [4];
        logic [3:0] a4, e4;
        n = int'(v.div) + 1;
        p = v.mode ? ((int'(v.fsr) + 1) / 2) * n : n;
        f = 64 * p;
        for (int k = 0; k < 4; k++) begin
            miss[k] = 0; mj[k] = 0; ma[k] = 0; me[k] = 0;
        end
        master_i = 1'b1;
        mck_out_i = v.mode;
        mck_div_i = v.div;
        fs_ratio_i = v.fsr;
        #1ns;
        check(cfg_bad_o == v.bad, "R5", "config error flag", int'(cfg_bad_o), int'(v.bad));
        ck_start_i = 1'b1;
        step();
        ck_start_i = 1'b0;
        if (v.bad) begin
            repeat (3) step();
            check(!gen_active_o && !bclk_o && !lrclk_o, "R5", "start with bad setting ignored",
                  int'(gen_active_o), 0);
            return;
        end
        last = (int'(v.stop_at) / f) * f + f - 1;
        for (int j = 0; j <= last + 3; j++) begin
            e4[0] = (j <= last);
            e4[1] = e4[0] && v.mode && ((j % n) >= n / 2);
            e4[2] = e4[0] && ((j % p) >= p / 2);
            e4[3] = e4[0] && (((j / p) % 64) >= 32);
            a4 = {lrclk_o, bclk_o, mclk_o, gen_active_o};
            for (int k = 0; k < 4; k++) begin
                if (a4[k] !== e4[k]) begin
                    if (miss[k] == 0) begin
                        mj[k] = j; ma[k] = int'(a4[k]); me[k] = int'(e4[k]);
                    end
                    miss[k]++;
                end
            end
            ck_stop_i = (j == int'(v.stop_at));
            if (v.poke && j == 20) begin
                mck_div_i = 6'd9;
                fs_ratio_i = 6'd0;
                mck_out_i = ~v.mode;
            end
            step();
        end
        ck_stop_i = 1'b0;
        check(miss[0] == 0, "R7", $sformatf("active window, cycle %0d", mj[0]), ma[0], me[0]);
        check(miss[1] == 0, "R2", $sformatf("master clock, cycle %0d", mj[1]), ma[1], me[1]);
        check(miss[2] == 0, "R3", $sformatf("bit clock, cycle %0d", mj[2]), ma[2], me[2]);
        check(miss[3] == 0, "R4", $sformatf("frame clock, cycle %0d", mj[3]), ma[3], me[3]);
        if (v.poke) begin
            check(miss[0] + miss[1] + miss[2] + miss[3] == 0, "R10",
                  "setting change while running", miss[0] + miss[1] + miss[2] + miss[3], 0);
        end
    endtask

    initial begin
        #2ns;
        // R1: values while reset is held
        check({mclk_o, bclk_o, lrclk_o, gen_active_o} == 4'b0, "R1", "outputs in reset",
              int'({mclk_o, bclk_o, lrclk_o, gen_active_o}), 0);
        repeat (3) step();
        rst_n = 1'b1;
        repeat (2) step();
        check({mclk_o, bclk_o, lrclk_o, gen_active_o} == 4'b0, "R1", "outputs after reset",
              int'({mclk_o, bclk_o, lrclk_o, gen_active_o}), 0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i]);
            repeat (2) step();
        end

        // R6: slave mode ignores start
        master_i = 1'b0; mck_out_i = 1'b1; mck_div_i = 6'd1; fs_ratio_i = 6'd1;
        ck_start_i = 1'b1; step(); ck_start_i = 1'b0;
        repeat (4) step();
        check(!gen_active_o && !bclk_o, "R6", "start in slave mode", int'(gen_active_o), 0);
        master_i = 1'b1;

        // R8: stop alone while idle, then start and stop together
        ck_stop_i = 1'b1; step(); ck_stop_i = 1'b0; step();
        check(!gen_active_o, "R8", "stop while idle", int'(gen_active_o), 0);
        ck_start_i = 1'b1; ck_stop_i = 1'b1; step();
        ck_start_i = 1'b0; ck_stop_i = 1'b0; step();
        check(!gen_active_o && !lrclk_o, "R8", "start with stop same cycle", int'(gen_active_o), 0);

        // R9: start during drain cancels the stop; start during run keeps phase (P=2, frame 128)
        ck_start_i = 1'b1; step(); ck_start_i = 1'b0;
        for (int j = 0; j < 200; j++) begin
            ck_stop_i  = (j == 10);
            ck_start_i = (j == 20) || (j == 150);
            step();
        end
        ck_start_i = 1'b0; ck_stop_i = 1'b0;
        check(gen_active_o == 1'b1, "R9", "running after cancelled stop", int'(gen_active_o), 1);
        check(lrclk_o == 1'b1, "R9", "frame phase kept at cycle 200", int'(lrclk_o), 1);
        check(bclk_o == 1'b0, "R9", "bit phase kept at cycle 200", int'(bclk_o), 0);
        ck_stop_i = 1'b1; step(); ck_stop_i = 1'b0;
        for (int j = 201; j < 255; j++) step();
        check(gen_active_o && lrclk_o && bclk_o, "R7", "last cycle of frame still running",
              int'({gen_active_o, lrclk_o, bclk_o}), 7);
        step();
        check(!gen_active_o && !lrclk_o && !bclk_o && !mclk_o, "R7", "idle after frame end",
              int'({gen_active_o, lrclk_o, bclk_o, mclk_o}), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1500us;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule